// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a pointing-device event into a five-byte packet of the kind a serial mouse sends, and stores the bytes in an on-chip byte queue for a host to drain one byte at a time. An event carries signed horizontal and vertical motion and the state of three buttons, qualified by a one-cycle strobe. The packet opens with a marker byte that also carries the buttons. Two clamped motion bytes follow, and the packet ends with two zero padding bytes.

The host watches a byte-available flag and pulses a read request. The byte comes back on the read port one cycle later. The encoder fills the queue at one byte per clock. Bytes that arrive when the queue is full are lost without any indication, which matches the usual behaviour of such a device when the host falls behind.

Top module: `mouse_pkt_enc_top`

## Requirements
- R1: Each accepted event writes exactly five bytes to the queue, in this order: marker, X motion, Y motion, 0x00, 0x00.
- R2: The marker byte is 0x87 with bit 2 cleared when the left button is held, bit 1 cleared when the middle button is held, and bit 0 cleared when the right button is held.
- R3: The X motion byte is the signed input clamped to the range -127..+127 and sent as 8-bit two's complement (+127 is 0x7F, -127 is 0x81).
- R4: The Y motion byte is the input with its sign inverted, then clamped to -127..+127 and sent as 8-bit two's complement. The inversion is done at full width, so the most negative input gives 0x7F.
- R5: The queue is circular and holds DEPTH bytes. A byte written while DEPTH bytes are stored is dropped, and the stored bytes keep their order and values. A write and a read in the same cycle on a full queue still drops the write.
- R6: After reset the byte-available flag is low and the read port is 0x00. A read request made while the queue is empty returns 0x00 and changes nothing.
- R7: A read request returns the oldest stored byte on the read port on the next clock edge. The byte-available flag updates on that same edge and stays high while any byte remains.
- R8: An accepted strobe starts the writes on the following edge, one byte per clock, over five consecutive clocks. A strobe that arrives before the fifth byte has been written is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_dx | input | DELTA_W | Signed horizontal motion |
| evt_dy | input | DELTA_W | Signed vertical motion |
| btn_left | input | 1 | Left button held |
| btn_mid | input | 1 | Middle button held |
| btn_right | input | 1 | Right button held |
| rd_en | input | 1 | Read request for one byte |
| byte_avail | output | 1 | At least one byte is stored |
| rd_data | output | 8 | Byte returned by the last read request |

## Verification
An event strobe sampled at edge N produces queue writes at edges N+1 through N+5. For that reason the bench waits five clocks past the accepting edge before it reads anything, and its reference queue only changes after that point. A read request sampled at edge M updates both the read port and the byte-available flag at edge M. The bench drives each request for one cycle and samples both outputs at the falling edge that follows. This means every byte comparison and every flag comparison is made against the reference queue in the same cycle the design produces the result.

// File: rtl/mpe_pkg.sv
package mpe_pkg;

    localparam int PKT_LEN   = 5;
    localparam int SLOT_W    = $clog2(PKT_LEN);
    localparam logic [7:0] MARKER_BASE = 8'h87;
    localparam logic [7:0] PAD_BYTE    = 8'h00;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_MARK = 3'd0,
        SLOT_X    = 3'd1,
        SLOT_Y    = 3'd2,
        SLOT_PAD0 = 3'd3,
        SLOT_PAD1 = 3'd4
    } slot_e;

    typedef struct packed {
        logic [7:0] mark;
        logic [7:0] xmot;
        logic [7:0] ymot;
    } pkt_s;

    function automatic logic [7:0] marker_byte(input logic l, input logic m, input logic r);
        return MARKER_BASE & ~{5'b0, l, m, r};
    endfunction

endpackage

// File: rtl/mpe_packer.sv
module mpe_packer
    import mpe_pkg::*;
#(
    parameter int DELTA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic [DELTA_W-1:0] evt_dx,
    input  logic [DELTA_W-1:0] evt_dy,
    input  logic               btn_left,
    input  logic               btn_mid,
    input  logic               btn_right,
    output logic               wr_en,
    output logic [7:0]         wr_byte,
    output slot_e              slot,
    output logic               busy
);

    localparam int EXT_W = DELTA_W + 1;
    localparam logic signed [EXT_W-1:0] LIM_HI = EXT_W'(127);
    localparam logic signed [EXT_W-1:0] LIM_LO = -EXT_W'(127);

    function automatic logic [7:0] clamp8(input logic signed [EXT_W-1:0] v);
        if (v > LIM_HI)      return 8'h7F;
        else if (v < LIM_LO) return 8'h81;
        else                 return v[7:0];
    endfunction

    pkt_s                      pkt_q;
    logic signed [EXT_W-1:0]   dx_ext;
    logic signed [EXT_W-1:0]   dy_neg;

    always_comb begin
        dx_ext = $signed({evt_dx[DELTA_W-1], evt_dx});
        dy_neg = -$signed({evt_dy[DELTA_W-1], evt_dy});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            slot  <= SLOT_MARK;
            pkt_q <= '0;
        end else if (!busy) begin
            if (evt_valid) begin
                busy       <= 1'b1;
                slot       <= SLOT_MARK;
                pkt_q.mark <= marker_byte(btn_left, btn_mid, btn_right);
                pkt_q.xmot <= clamp8(dx_ext);
                pkt_q.ymot <= clamp8(dy_neg);
            end
        end else begin
            if (slot == SLOT_PAD1) begin
                busy <= 1'b0;
                slot <= SLOT_MARK;
            end else begin
                slot <= slot_e'(slot + 1'b1);
            end
        end
    end

    always_comb begin
        wr_en = busy;
        unique case (slot)
            SLOT_MARK: wr_byte = pkt_q.mark;
            SLOT_X:    wr_byte = pkt_q.xmot;
            SLOT_Y:    wr_byte = pkt_q.ymot;
            default:   wr_byte = PAD_BYTE;
        endcase
    end

endmodule

// File: rtl/mpe_byte_queue.sv
module mpe_byte_queue #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [7:0]               wr_byte,
    input  logic                     rd_en,
    output logic                     avail,
    output logic [7:0]               rd_data,
    output logic [$clog2(DEPTH):0]   count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_wr = wr_en && (count != FULL_CNT);
        do_rd = rd_en && (count != '0);
        avail = (count != '0);
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= 8'h00;
        end else begin
            if (do_wr) wptr <= step(wptr);
            if (rd_en) rd_data <= do_rd ? mem[rptr] : 8'h00;
            if (do_rd) rptr <= step(rptr);
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

endmodule

// File: rtl/mouse_pkt_enc_top.sv
module mouse_pkt_enc_top
    import mpe_pkg::*;
#(
    parameter int DELTA_W = 16,
    parameter int DEPTH   = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic [DELTA_W-1:0] evt_dx,
    input  logic [DELTA_W-1:0] evt_dy,
    input  logic               btn_left,
    input  logic               btn_mid,
    input  logic               btn_right,
    input  logic               rd_en,
    output logic               byte_avail,
    output logic [7:0]         rd_data
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          pk_wr;
    logic [7:0]    pk_byte;
    slot_e         pk_slot;
    logic          pk_busy;
    logic [CW-1:0] q_count;

    mpe_packer #(.DELTA_W(DELTA_W)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_dx    (evt_dx),
        .evt_dy    (evt_dy),
        .btn_left  (btn_left),
        .btn_mid   (btn_mid),
        .btn_right (btn_right),
        .wr_en     (pk_wr),
        .wr_byte   (pk_byte),
        .slot      (pk_slot),
        .busy      (pk_busy)
    );

    mpe_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pk_wr),
        .wr_byte (pk_byte),
        .rd_en   (rd_en),
        .avail   (byte_avail),
        .rd_data (rd_data),
        .count   (q_count)
    );

endmodule

// File: rtl/mpe_checker.sv
module mpe_checker
    import mpe_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    evt_valid,
    input logic                    rd_en,
    input logic                    byte_avail,
    input logic [7:0]              rd_data,
    input logic                    pk_wr,
    input logic [7:0]              pk_byte,
    input slot_e                   pk_slot,
    input logic                    pk_busy,
    input logic [$clog2(DEPTH):0]  q_count
);

    localparam int CW = $clog2(DEPTH) + 1;

    // R1: padding slots carry zero
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && (pk_slot == SLOT_PAD0 || pk_slot == SLOT_PAD1)) |-> (pk_byte == 8'h00));

    // R2: marker keeps its fixed upper bits
    p_marker_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && pk_slot == SLOT_MARK) |-> (pk_byte[7:3] == 5'b10000));

    // R3: X byte never takes the unclamped extreme
    p_x_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && pk_slot == SLOT_X) |-> (pk_byte != 8'h80));

    // R4: Y byte never takes the unclamped extreme
    p_y_clamped_r4: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && pk_slot == SLOT_Y) |-> (pk_byte != 8'h80));

    // R5: occupancy bounded, full queue does not grow
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));
    p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (q_count == CW'(DEPTH) && !rd_en) |=> (q_count == CW'(DEPTH)));

    // R6: empty read returns zero
    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !byte_avail) |=> (rd_data == 8'h00));

    // R7: flag tracks occupancy
    p_avail_count_r7: assert property (@(posedge clk) disable iff (rst)
        byte_avail == (q_count != '0));

    // R8: slots advance one per clock, gap after the last one
    p_slot_step_r8: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && pk_slot != SLOT_PAD1) |=> (pk_wr && pk_slot == slot_e'($past(pk_slot) + 1'b1)));
    p_gap_after_pkt_r8: assert property (@(posedge clk) disable iff (rst)
        (pk_wr && pk_slot == SLOT_PAD1) |=> !pk_wr);
    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!pk_busy && evt_valid) |=> (pk_wr && pk_slot == SLOT_MARK));

endmodule

bind mouse_pkt_enc_top mpe_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .rd_en      (rd_en),
    .byte_avail (byte_avail),
    .rd_data    (rd_data),
    .pk_wr      (pk_wr),
    .pk_byte    (pk_byte),
    .pk_slot    (pk_slot),
    .pk_busy    (pk_busy),
    .q_count    (q_count)
);

// File: tb/mouse_pkt_enc_top_tb.sv
module mouse_pkt_enc_top_tb;

    localparam int DELTA_W = 16;
    localparam int DEPTH   = 256;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               evt_valid = 1'b0;
    logic [DELTA_W-1:0] evt_dx = '0;
    logic [DELTA_W-1:0] evt_dy = '0;
    logic               btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
    logic               rd_en = 1'b0;
    logic               byte_avail;
    logic [7:0]         rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] model [$];

    always #2.5 clk = ~clk;

    mouse_pkt_enc_top #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_dx(evt_dx), .evt_dy(evt_dy),
        .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
        .rd_en(rd_en), .byte_avail(byte_avail), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_clamp(input int v);
        if (v > 127)  return 8'h7F;
        if (v < -127) return 8'h81;
        return 8'(v);
    endfunction

    function automatic logic [7:0] exp_mark(input bit l, input bit m, input bit r);
        logic [7:0] b = 8'h87;
        if (l) b[2] = 1'b0;
        if (m) b[1] = 1'b0;
        if (r) b[0] = 1'b0;
        return b;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [7:0] b);
        if (model.size() < DEPTH) model.push_back(b);
    endtask

    // strobe accepted at edge N; writes at N+1..N+5
    task automatic send_event(input int dx, input int dy, input bit l, input bit m, input bit r);
        @(negedge clk);
        evt_dx = DELTA_W'(dx); evt_dy = DELTA_W'(dy);
        btn_left = l; btn_mid = m; btn_right = r;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (5) @(negedge clk);
        model_push(exp_mark(l, m, r));
        model_push(exp_clamp(dx));
        model_push(exp_clamp(-dy));
        model_push(8'h00);
        model_push(8'h00);
    endtask

    task automatic read_one(input string req);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        exp = (model.size() == 0) ? 8'h00 : model.pop_front();
        check(req, rd_data, exp);
        check("R7 avail", {7'b0, byte_avail}, {7'b0, model.size() != 0});
    endtask

    task automatic drain(input string req);
        while (model.size() != 0) read_one(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 reset state
        check("R6 reset avail", {7'b0, byte_avail}, 8'h00);
        check("R6 reset data", rd_data, 8'h00);
        read_one("R6 empty read");

        // R1 R2 R3 R4 directed packets
        send_event(5, 3, 0, 0, 0);       drain("R1 plain packet");
        send_event(-7, -9, 1, 0, 0);     drain("R2 left");
        send_event(0, 0, 0, 1, 0);       drain("R2 middle");
        send_event(1, 1, 0, 0, 1);       drain("R2 right");
        send_event(2, 2, 1, 1, 1);       drain("R2 all");
        send_event(300, -200, 0, 0, 0);  drain("R3 R4 clamp");
        send_event(-300, 200, 0, 0, 0);  drain("R3 R4 clamp neg");
        send_event(127, -127, 0, 0, 0);  drain("R3 R4 edge");
        send_event(-128, 128, 0, 0, 0);  drain("R3 R4 edge+1");
        send_event(-32768, -32768, 0, 0, 0); drain("R4 most negative");

        // R8 second strobe while writing is ignored
        @(negedge clk);
        evt_dx = 16'd10; evt_dy = 16'd20; {btn_left, btn_mid, btn_right} = 3'b000;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_dx = 16'd99; evt_dy = 16'd99; btn_left = 1'b1;
        repeat (3) @(negedge clk);
        evt_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_push(8'h87); model_push(8'h0A); model_push(8'hEC);
        model_push(8'h00); model_push(8'h00);
        drain("R8 busy ignore");
        check("R8 nothing extra", {7'b0, byte_avail}, 8'h00);

        // random events
        for (int i = 0; i < 30; i++) begin
            int dx = int'($urandom_range(0, 800)) - 400;
            int dy = int'($urandom_range(0, 800)) - 400;
            logic [2:0] b = 3'($urandom);
            send_event(dx, dy, b[2], b[1], b[0]);
            if (($urandom % 3) == 0) drain("R1 random");
        end
        drain("R7 random drain");

        // R5 overflow: 52 events = 260 bytes, last 4 dropped
        for (int i = 0; i < 52; i++) send_event(i, -i, i[0], i[1], i[2]);
        check("R5 full avail", {7'b0, byte_avail}, 8'h01);
        // simultaneous read with write on full queue drops the write
        @(negedge clk);
        evt_dx = 16'd3; evt_dy = 16'd4; evt_valid = 1'b1;
        {btn_left, btn_mid, btn_right} = 3'b000;
        @(negedge clk);
        evt_valid = 1'b0;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 read during full", rd_data, model.pop_front());
        repeat (5) @(negedge clk);
        // freed slot accepted a later byte of that packet (slot 1 onward)
        model_push(exp_clamp(3)); model_push(exp_clamp(-4));
        model_push(8'h00); model_push(8'h00);
        while (model.size() > DEPTH) void'(model.pop_back());
        drain("R5 overflow order");
        check("R7 empty at end", {7'b0, byte_avail}, 8'h00);
        read_one("R6 empty after drain");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule